// File: doc/BRIEF.md
# Equalizer Boot and Fast-Load Controller

This block is the control engine that takes an audio equalizer and converter core from reset to normal operation. Power alone gives it no defined state. It needs an explicit reset. Reset first sweeps every word of the coefficient RAM with all-pass data: each band gets a unity leading tap and zero for its other taps. It then waits out a settling interval whose length is set by a parameter. At the end of that interval it loads default levels and opens the host port. The host port accepts nothing while initialization runs.

The block comes out of initialization in fast-load mode. In this mode the audio engine is held, so the host can download equalizer coefficients without stalling any processing. Serial audio is refused in this mode, and so are tone (bass and treble) writes. A control-register write with the mode bit cleared starts normal processing and records the serial format bits in the same write. Only a new reset brings fast-load back.

Top module: `eqBootCtrl`

## Requirements
- R1: While reset is held, the control register reads 0x80, with bit 7 being the fast-load flag and the other bits 0. `fastLoad` is 1, and `initDone`, `audioRun` and `hostAccept` are 0.
- R2: After reset is released, the block issues one RAM write per cycle. The addresses run from 0 to DEPTH-1 in ascending order, where DEPTH = 5*NUM_BANDS. The data is UNITY_COEF where the address modulo 5 is 0, and 0 elsewhere. No further sweep write follows.
- R3: `initDone` rises exactly DEPTH+INIT_CYCLES cycles after reset release. Before that, no host write raises `hostAccept` or `hostErr`, and no host write changes any register.
- R4: When initialization completes, bass and treble read 0x00 (flat), mixer 1 gain reads 0x00 (0 dB), mixer 2 gain reads 0xFF (mute), volume reads 0xFF (mute), and fast-load is active.
- R5: While fast-load is active, `audioRun` and `audioAccept` stay 0 whatever `audioInValid` does.
- R6: A host address with its top bit set selects RAM index hostAddr[RAM_AW-1:0]. An index below DEPTH is accepted in either mode and drives `ramWe`, `ramAddr` and `ramData` in the same cycle. A higher index is rejected.
- R7: Register addresses 1 (bass) and 2 (treble) are rejected in fast-load mode. In normal mode they are accepted and store hostData[7:0].
- R8: Register addresses 3 (mixer 1), 4 (mixer 2) and 5 (volume) are accepted in both modes and store hostData[7:0].
- R9: A write to register address 0 with bit 7 equal to 0 ends fast-load. Bits 6:0, which include the serial format, are stored. `audioRun` then reads 1.
- R10: In normal mode, a write to address 0 with bit 7 equal to 1 still stores bits 6:0, but fast-load stays off.
- R11: A write to any register address from 6 upward, or any rejected write, pulses `hostErr` for the cycle of the write, leaves `hostAccept` low and changes no register.
- R12: In normal mode, `audioAccept` follows `audioInValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | RAM_AW+1 | Host address; top bit selects RAM |
| hostData | input | COEF_W | Host write data |
| hostAccept | output | 1 | Write accepted this cycle |
| hostErr | output | 1 | Write rejected this cycle |
| ramWe | output | 1 | Coefficient RAM write enable |
| ramAddr | output | RAM_AW | Coefficient RAM address |
| ramData | output | COEF_W | Coefficient RAM write data |
| audioInValid | input | 1 | Serial audio sample present |
| audioRun | output | 1 | Audio engine enable |
| audioAccept | output | 1 | Serial audio sample taken |
| initDone | output | 1 | Initialization finished |
| fastLoad | output | 1 | Fast-load mode active |
| ctrlReg | output | 8 | Control register |
| bassLvl | output | 8 | Bass level |
| trebleLvl | output | 8 | Treble level |
| mix1Gain | output | 8 | Mixer input 1 attenuation |
| mix2Gain | output | 8 | Mixer input 2 attenuation |
| volLvl | output | 8 | Volume attenuation |

## Verification
The hardest case to reach is a host write that arrives during the boot sweep or the settling wait. Such a write must be neither acknowledged nor rejected. The stimulus holds a write of 0 to the control register active from the cycle reset drops until the cycle `initDone` rises. It counts each sampled cycle to confirm that the sweep order, the data and the completion cycle all match. The bench also sweeps the whole host address space in both modes. A model in the bench computes accept or reject and the expected register contents for every address.

// File: rtl/eqBootPkg.sv
package eqBootPkg;
  typedef enum logic [1:0] {ST_CLEAR, ST_WAIT, ST_RUN} bootState_t;

  typedef struct packed {
    logic loadDflt;
    logic wrCtrl;
    logic wrBass;
    logic wrTreble;
    logic wrMix1;
    logic wrMix2;
    logic wrVol;
  } regStrobe_t;

  localparam int REG_CTRL   = 0;
  localparam int REG_BASS   = 1;
  localparam int REG_TREBLE = 2;
  localparam int REG_MIX1   = 3;
  localparam int REG_MIX2   = 4;
  localparam int REG_VOL    = 5;

  localparam logic [7:0] CTRL_BOOT  = 8'h80;
  localparam logic [7:0] TONE_FLAT  = 8'h00;
  localparam logic [7:0] GAIN_UNITY = 8'h00;
  localparam logic [7:0] GAIN_MUTE  = 8'hFF;
  localparam int TAPS_PER_BAND = 5;
endpackage

// File: rtl/eqBootFsm.sv
module eqBootFsm
  import eqBootPkg::*;
#(
  parameter int NUM_BANDS   = 4,
  parameter int COEF_W      = 16,
  parameter int INIT_CYCLES = 12,
  parameter int UNITY_COEF  = 16384,
  localparam int DEPTH   = NUM_BANDS * TAPS_PER_BAND,
  localparam int RAM_AW  = $clog2(DEPTH),
  localparam int HADDR_W = RAM_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hostWrEn,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic [COEF_W-1:0]  hostData,
  input  logic               fastLoad,
  output logic               initDone,
  output logic               hostAccept,
  output logic               hostErr,
  output logic               ramWe,
  output logic [RAM_AW-1:0]  ramAddr,
  output logic [COEF_W-1:0]  ramData,
  output regStrobe_t         strobe
);
  localparam int CLR_W = $clog2(DEPTH + 1);
  localparam int WT_W  = $clog2(INIT_CYCLES + 1);
  localparam int CNT_W = (CLR_W > WT_W) ? CLR_W : WT_W;

  bootState_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              clearWe;
  logic              isRam;
  logic [RAM_AW-1:0] idx;
  logic              legal;
  logic              regLegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CLEAR;
      cnt   <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          if (cnt == CNT_W'(DEPTH - 1)) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt == CNT_W'(INIT_CYCLES - 1)) begin
            state <= ST_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign initDone = (state == ST_RUN);
  assign clearWe  = (state == ST_CLEAR) && !rst;
  assign isRam    = hostAddr[HADDR_W-1];
  assign idx      = hostAddr[RAM_AW-1:0];

  always_comb begin
    case (idx)
      RAM_AW'(REG_CTRL), RAM_AW'(REG_MIX1),
      RAM_AW'(REG_MIX2), RAM_AW'(REG_VOL):   regLegal = 1'b1;
      RAM_AW'(REG_BASS), RAM_AW'(REG_TREBLE): regLegal = !fastLoad;
      default:                                regLegal = 1'b0;
    endcase
    legal = isRam ? ({1'b0, idx} < HADDR_W'(DEPTH)) : regLegal;
  end

  assign hostAccept = hostWrEn && initDone && legal;
  assign hostErr    = hostWrEn && initDone && !legal;

  always_comb begin
    strobe          = '0;
    strobe.loadDflt = (state == ST_WAIT) && (cnt == CNT_W'(INIT_CYCLES - 1)) && !rst;
    if (hostAccept && !isRam) begin
      strobe.wrCtrl   = (idx == RAM_AW'(REG_CTRL));
      strobe.wrBass   = (idx == RAM_AW'(REG_BASS));
      strobe.wrTreble = (idx == RAM_AW'(REG_TREBLE));
      strobe.wrMix1   = (idx == RAM_AW'(REG_MIX1));
      strobe.wrMix2   = (idx == RAM_AW'(REG_MIX2));
      strobe.wrVol    = (idx == RAM_AW'(REG_VOL));
    end
  end

  always_comb begin
    if (clearWe) begin
      ramWe   = 1'b1;
      ramAddr = cnt[RAM_AW-1:0];
      ramData = ((cnt % CNT_W'(TAPS_PER_BAND)) == '0) ? COEF_W'(UNITY_COEF) : '0;
    end else begin
      ramWe   = hostAccept && isRam;
      ramAddr = idx;
      ramData = hostData;
    end
  end
endmodule

// File: rtl/eqBootRegs.sv
module eqBootRegs
  import eqBootPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  regStrobe_t strobe,
  input  logic [7:0] wrData,
  input  logic       initDone,
  input  logic       audioInValid,
  output logic       fastLoad,
  output logic       audioRun,
  output logic       audioAccept,
  output logic [7:0] ctrlReg,
  output logic [7:0] bassLvl,
  output logic [7:0] trebleLvl,
  output logic [7:0] mix1Gain,
  output logic [7:0] mix2Gain,
  output logic [7:0] volLvl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg   <= CTRL_BOOT;
      bassLvl   <= TONE_FLAT;
      trebleLvl <= TONE_FLAT;
      mix1Gain  <= GAIN_UNITY;
      mix2Gain  <= GAIN_MUTE;
      volLvl    <= GAIN_MUTE;
    end else begin
      if (strobe.loadDflt) begin
        ctrlReg[7] <= 1'b1;
        bassLvl    <= TONE_FLAT;
        trebleLvl  <= TONE_FLAT;
        mix1Gain   <= GAIN_UNITY;
        mix2Gain   <= GAIN_MUTE;
        volLvl     <= GAIN_MUTE;
      end
      if (strobe.wrCtrl) begin
        // mode bit can only fall; only reset raises it again
        ctrlReg <= {ctrlReg[7] & wrData[7], wrData[6:0]};
      end
      if (strobe.wrBass)   bassLvl   <= wrData;
      if (strobe.wrTreble) trebleLvl <= wrData;
      if (strobe.wrMix1)   mix1Gain  <= wrData;
      if (strobe.wrMix2)   mix2Gain  <= wrData;
      if (strobe.wrVol)    volLvl    <= wrData;
    end
  end

  assign fastLoad    = ctrlReg[7];
  assign audioRun    = initDone && !fastLoad;
  assign audioAccept = audioRun && audioInValid;
endmodule

// File: rtl/eqBootCtrl.sv
module eqBootCtrl
  import eqBootPkg::*;
#(
  parameter int NUM_BANDS   = 4,
  parameter int COEF_W      = 16,
  parameter int INIT_CYCLES = 12,
  parameter int UNITY_COEF  = 16384,
  localparam int DEPTH   = NUM_BANDS * TAPS_PER_BAND,
  localparam int RAM_AW  = $clog2(DEPTH),
  localparam int HADDR_W = RAM_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hostWrEn,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic [COEF_W-1:0]  hostData,
  output logic               hostAccept,
  output logic               hostErr,
  output logic               ramWe,
  output logic [RAM_AW-1:0]  ramAddr,
  output logic [COEF_W-1:0]  ramData,
  input  logic               audioInValid,
  output logic               audioRun,
  output logic               audioAccept,
  output logic               initDone,
  output logic               fastLoad,
  output logic [7:0]         ctrlReg,
  output logic [7:0]         bassLvl,
  output logic [7:0]         trebleLvl,
  output logic [7:0]         mix1Gain,
  output logic [7:0]         mix2Gain,
  output logic [7:0]         volLvl
);
  regStrobe_t strobe;

  eqBootFsm #(
    .NUM_BANDS(NUM_BANDS), .COEF_W(COEF_W),
    .INIT_CYCLES(INIT_CYCLES), .UNITY_COEF(UNITY_COEF)
  ) i_fsm (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostData(hostData), .fastLoad(fastLoad), .initDone(initDone),
    .hostAccept(hostAccept), .hostErr(hostErr), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData), .strobe(strobe)
  );

  eqBootRegs i_regs (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(hostData[7:0]),
    .initDone(initDone), .audioInValid(audioInValid), .fastLoad(fastLoad),
    .audioRun(audioRun), .audioAccept(audioAccept), .ctrlReg(ctrlReg),
    .bassLvl(bassLvl), .trebleLvl(trebleLvl), .mix1Gain(mix1Gain),
    .mix2Gain(mix2Gain), .volLvl(volLvl)
  );
endmodule

// File: rtl/eqBootChecker.sv
module eqBootChecker #(
  parameter int RAM_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              hostAccept,
  input logic              hostErr,
  input logic              ramWe,
  input logic [RAM_AW-1:0] ramAddr,
  input logic              audioRun,
  input logic              audioAccept,
  input logic              initDone,
  input logic              fastLoad,
  input logic [7:0]        bassLvl,
  input logic [7:0]        trebleLvl,
  input logic [7:0]        mix2Gain,
  input logic [7:0]        volLvl
);
  assert_busy_silent_R3: assert property (@(posedge clk) disable iff (rst)
    !initDone |-> (!hostAccept && !hostErr));

  assert_sweep_ascends_R2: assert property (@(posedge clk) disable iff (rst)
    (!initDone && ramWe && ramAddr != '0) |-> (ramAddr == $past(ramAddr) + 1'b1));

  assert_boot_defaults_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(initDone) |-> (fastLoad && mix2Gain == 8'hFF && volLvl == 8'hFF && bassLvl == 8'h00));

  assert_engine_held_R5: assert property (@(posedge clk) disable iff (rst)
    fastLoad |-> (!audioRun && !audioAccept));

  assert_no_reentry_R10: assert property (@(posedge clk) disable iff (rst)
    !fastLoad |=> !fastLoad);

  assert_reject_keeps_R11: assert property (@(posedge clk) disable iff (rst)
    hostErr |=> ($stable(bassLvl) && $stable(trebleLvl) && $stable(volLvl) && $stable(mix2Gain)));

  assert_ack_err_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(hostAccept && hostErr));
endmodule

bind eqBootCtrl eqBootChecker #(.RAM_AW(RAM_AW)) i_chk (.*);

// File: tb/test_eqBootCtrl.sv
module test_eqBootCtrl;
  localparam int CLK_PERIOD  = 10;
  localparam int NUM_BANDS   = 4;
  localparam int COEF_W      = 16;
  localparam int INIT_CYCLES = 12;
  localparam int UNITY_COEF  = 16384;
  localparam int DEPTH       = NUM_BANDS * 5;
  localparam int RAM_AW      = $clog2(DEPTH);
  localparam int HADDR_W     = RAM_AW + 1;

  logic clk = 0;
  logic rst = 1;
  logic hostWrEn = 0;
  logic [HADDR_W-1:0] hostAddr = '0;
  logic [COEF_W-1:0] hostData = '0;
  logic audioInValid = 0;
  logic hostAccept, hostErr, ramWe, audioRun, audioAccept, initDone, fastLoad;
  logic [RAM_AW-1:0] ramAddr;
  logic [COEF_W-1:0] ramData;
  logic [7:0] ctrlReg, bassLvl, trebleLvl, mix1Gain, mix2Gain, volLvl;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] eCtrl, eBass, eTreble, eMix1, eMix2, eVol;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eqBootCtrl #(
    .NUM_BANDS(NUM_BANDS), .COEF_W(COEF_W),
    .INIT_CYCLES(INIT_CYCLES), .UNITY_COEF(UNITY_COEF)
  ) i_eqBootCtrl (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostData(hostData), .hostAccept(hostAccept), .hostErr(hostErr),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .audioInValid(audioInValid), .audioRun(audioRun), .audioAccept(audioAccept),
    .initDone(initDone), .fastLoad(fastLoad), .ctrlReg(ctrlReg),
    .bassLvl(bassLvl), .trebleLvl(trebleLvl), .mix1Gain(mix1Gain),
    .mix2Gain(mix2Gain), .volLvl(volLvl)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkRegs(input string tag);
    chk(ctrlReg, eCtrl, {tag, " ctrl"});
    chk(bassLvl, eBass, {tag, " bass"});
    chk(trebleLvl, eTreble, {tag, " treble"});
    chk(mix1Gain, eMix1, {tag, " mix1"});
    chk(mix2Gain, eMix2, {tag, " mix2"});
    chk(volLvl, eVol, {tag, " vol"});
    chk(fastLoad, eCtrl[7], {tag, " mode"});
  endtask

  task automatic bootDefaults();
    eCtrl = 8'h80; eBass = 8'h00; eTreble = 8'h00;
    eMix1 = 8'h00; eMix2 = 8'hFF; eVol = 8'hFF;
  endtask

  // reset, hold a control write through boot, check sweep and timing
  task automatic runBoot();
    int n = 0;
    bit done = 0;
    int expData;
    @(posedge clk); #1;
    rst = 1; hostWrEn = 1; hostAddr = '0; hostData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ctrlReg, 8'h80, "R1 ctrl in reset");
    chk(fastLoad, 1, "R1 mode in reset");
    chk(initDone, 0, "R1 done in reset");
    chk(audioRun, 0, "R1 run in reset");
    chk(hostAccept, 0, "R1 accept in reset");
    @(posedge clk); #1;
    rst = 0;
    while (!done) begin
      @(negedge clk);
      if (initDone) begin
        done = 1;
        hostWrEn = 0;
      end else begin
        chk(hostAccept, 0, "R3 no accept while booting");
        chk(hostErr, 0, "R3 no error while booting");
        if (n < DEPTH) begin
          expData = (n % 5 == 0) ? UNITY_COEF : 0;
          chk(ramWe, 1, "R2 sweep write");
          chk(ramAddr, n, "R2 sweep addr");
          chk(ramData, expData, "R2 sweep data");
        end else begin
          chk(ramWe, 0, "R2 no extra write");
        end
        n++;
      end
    end
    chk(n, DEPTH + INIT_CYCLES, "R3 boot length");
    bootDefaults();
    chkRegs("R4");
  endtask

  task automatic doWrite(input logic [HADDR_W-1:0] a, input logic [COEF_W-1:0] d);
    bit isRam = a[HADDR_W-1];
    int idx = int'(a[RAM_AW-1:0]);
    bit legal;
    string tag;
    if (isRam) begin
      legal = idx < DEPTH; tag = "R6";
    end else if (idx == 0) begin
      legal = 1; tag = eCtrl[7] ? "R9" : "R10";
    end else if (idx == 1 || idx == 2) begin
      legal = !eCtrl[7]; tag = "R7";
    end else if (idx >= 3 && idx <= 5) begin
      legal = 1; tag = "R8";
    end else begin
      legal = 0; tag = "R11";
    end
    @(posedge clk); #1;
    hostWrEn = 1; hostAddr = a; hostData = d;
    @(negedge clk);
    chk(hostAccept, legal, {tag, " accept"});
    chk(hostErr, !legal, {tag, " error"});
    if (isRam && legal) begin
      chk(ramWe, 1, "R6 ram we");
      chk(ramAddr, idx, "R6 ram addr");
      chk(ramData, d, "R6 ram data");
    end else begin
      chk(ramWe, 0, {tag, " no ram write"});
    end
    @(posedge clk); #1;
    hostWrEn = 0;
    if (legal && !isRam) begin
      case (idx)
        0: eCtrl = {eCtrl[7] & d[7], d[6:0]};
        1: eBass = d[7:0];
        2: eTreble = d[7:0];
        3: eMix1 = d[7:0];
        4: eMix2 = d[7:0];
        default: eVol = d[7:0];
      endcase
    end
    @(negedge clk);
    chkRegs(tag);
  endtask

  task automatic sweepRegs(input int seed);
    for (int i = 1; i < (1 << RAM_AW); i++)
      doWrite(HADDR_W'(i), COEF_W'(seed + 7 * i));
  endtask

  task automatic sweepRam(input int seed);
    for (int i = 0; i < (1 << RAM_AW); i++)
      doWrite({1'b1, RAM_AW'(i)}, COEF_W'(seed + 37 * i));
  endtask

  initial begin
    runBoot();
    // R5: engine held while fast-load, audio refused
    audioInValid = 1;
    @(negedge clk);
    chk(audioRun, 0, "R5 run held");
    chk(audioAccept, 0, "R5 audio refused");
    sweepRam(1);
    sweepRegs(16'h10);
    @(negedge clk);
    chk(audioAccept, 0, "R5 audio refused after download");
    // R9: clear the mode bit, store format bits
    doWrite('0, 16'h0005);
    chk(audioRun, 1, "R9 run after exit");
    chk(audioAccept, 1, "R12 audio taken");
    audioInValid = 0;
    @(negedge clk);
    chk(audioAccept, 0, "R12 audio idle");
    sweepRegs(16'h40);
    sweepRam(5);
    // R10: mode bit set in normal mode does not re-enter
    doWrite('0, 16'h0083);
    chk(ctrlReg, 8'h03, "R10 ctrl value");
    chk(fastLoad, 0, "R10 stays normal");
    // second reset from normal mode
    runBoot();
    chk(audioRun, 0, "R5 run held after second boot");
    doWrite(HADDR_W'(1), 16'h0022);
    doWrite('0, 16'h0000);
    doWrite(HADDR_W'(2), 16'h0033);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule